// File: doc/BRIEF.md
# Paired-Block Interrupt Aggregator

This block collects the interrupt flags of eight serial channels, grouped as four blocks of two channels each. Every block keeps an 8-bit interrupt status byte and an 8-bit mask byte. Channel logic elsewhere sends one-cycle set and clear pulses for each channel's transmit-ready, receive-ready and break flags. The block merges the masked status of pairs of neighbouring blocks into two registered interrupt lines.

A host reaches the block with single-cycle read and write strobes, a 2-bit space code and an 8-bit address. In the register space it writes a block's mask and reads that block's status at the same address. In the identification and memory spaces it writes the interrupt vector byte. In the acknowledge space it reads the vector back for either line. Read data is registered: it appears in the cycle after the read strobe.

Top module: `irqagg_top`

## Requirements
- R1: While reset is low and in the cycle after it, `irq_line` is 0 and `host_rdata` is 0. Reset clears all status bytes, all mask bytes and the vector.
- R2: A set pulse for channel c raises one bit of the status byte of block c/2. Even channels use bit 0 (transmit-ready), bit 1 (receive-ready) and bit 2 (break). Odd channels use bits 4, 5 and 6 for the same flags. The bit can be read from the clock edge after the pulse. Bits 3 and 7 always read 0.
- R3: A clear pulse drops its status bit at the next edge. When a set pulse and a clear pulse for the same bit arrive in the same cycle, the bit ends up 0. A bit with no pulse keeps its value.
- R4: A write in space 0 to an address with bit 7 = 0 and bits [4:0] = 0x0A loads `host_wdata` into the mask of block addr[6:5]. A read at that address returns that block's status byte.
- R5: `irq_line[0]` is 1 exactly when (status AND mask) is nonzero in block 0 or block 1. `irq_line[1]` follows the same rule for blocks 2 and 3. Each line is a register: it reflects the status and mask held during the previous cycle.
- R6: A write at address 1 in space 1 (identification) or space 3 (memory) stores `host_wdata` as the vector. Writes at any other address in those spaces leave the vector unchanged.
- R7: A read in space 2 (acknowledge) at address 0 (line 0) or address 2 (line 1) returns the vector in the next cycle. An acknowledge read at any other address returns 0. Acknowledge reads change no status, mask or line.
- R8: A read in space 0 at any offset other than 0x0A, or with address bit 7 set, returns 0. A write there changes no mask. `host_rdata` is 0 in every cycle that follows a cycle with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_set | input | 8 | Per-channel transmit-ready set pulse |
| tx_clr | input | 8 | Per-channel transmit-ready clear pulse |
| rx_set | input | 8 | Per-channel receive-ready set pulse |
| rx_clr | input | 8 | Per-channel receive-ready clear pulse |
| brk_set | input | 8 | Per-channel break set pulse |
| brk_clr | input | 8 | Per-channel break clear pulse |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_space | input | 2 | Space code: 0 register, 1 identification, 2 acknowledge, 3 memory |
| host_addr | input | 8 | Host address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| irq_line | output | 2 | Interrupt lines, bit l serves blocks 2l and 2l+1 |

## Verification
A long stretch of random set and clear pulses runs together with random host traffic over all four spaces, including unmapped offsets. A behavioural model follows this traffic on every clock. Collisions between set and clear pulses show whether clear wins. Status held in one block of a pair, while the other block is masked, shows that the two blocks feed the line through an OR rather than only one of them. Directed steps then cover several things:
- each flag's bit position, for an even and an odd channel;
- the one-cycle latency of a line after a mask write;
- vector writes through both allowed spaces and through a refused address;
- acknowledge reads at the two serviced addresses and at an unserviced one.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int STAT_W = 8;

  typedef enum logic [1:0] {
    SP_REG   = 2'd0,
    SP_IDENT = 2'd1,
    SP_ACK   = 2'd2,
    SP_MEM   = 2'd3
  } space_e;

  localparam int FLAG_TX  = 0;
  localparam int FLAG_RX  = 1;
  localparam int FLAG_BRK = 2;

  localparam logic [4:0] LOC_INTREG = 5'h0A;

  // status bit of a flag: odd channels sit one nibble up
  function automatic int unsigned flag_pos(input int unsigned ch, input int unsigned flag);
    return (ch % 2) * 4 + flag;
  endfunction

  // clear dominates set, untouched bits hold
  function automatic logic [STAT_W-1:0] next_flags(input logic [STAT_W-1:0] cur,
                                                   input logic [STAT_W-1:0] set_v,
                                                   input logic [STAT_W-1:0] clr_v);
    return (cur | set_v) & ~clr_v;
  endfunction

  function automatic logic masked_any(input logic [STAT_W-1:0] st, input logic [STAT_W-1:0] mk);
    return |(st & mk);
  endfunction

endpackage

// File: rtl/irqagg_map.sv
module irqagg_map
  import irqagg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  localparam int NUM_CH = 2 * NUM_BLOCKS
) (
  input  logic [NUM_CH-1:0]                     tx_set,
  input  logic [NUM_CH-1:0]                     tx_clr,
  input  logic [NUM_CH-1:0]                     rx_set,
  input  logic [NUM_CH-1:0]                     rx_clr,
  input  logic [NUM_CH-1:0]                     brk_set,
  input  logic [NUM_CH-1:0]                     brk_clr,
  output logic [NUM_BLOCKS-1:0][STAT_W-1:0]     set_vec,
  output logic [NUM_BLOCKS-1:0][STAT_W-1:0]     clr_vec
);

  always_comb begin
    set_vec = '0;
    clr_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      set_vec[c/2][flag_pos(c, FLAG_TX)]  = tx_set[c];
      set_vec[c/2][flag_pos(c, FLAG_RX)]  = rx_set[c];
      set_vec[c/2][flag_pos(c, FLAG_BRK)] = brk_set[c];
      clr_vec[c/2][flag_pos(c, FLAG_TX)]  = tx_clr[c];
      clr_vec[c/2][flag_pos(c, FLAG_RX)]  = rx_clr[c];
      clr_vec[c/2][flag_pos(c, FLAG_BRK)] = brk_clr[c];
    end
  end

endmodule

// File: rtl/irqagg_blk.sv
module irqagg_blk
  import irqagg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  input  logic              mask_we,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= next_flags(status_q, set_vec, clr_vec);
      if (mask_we) mask_q <= mask_wdata;
    end
  end

  assign pend = masked_any(status_q, mask_q);

endmodule

// File: rtl/irqagg_dec.sv
module irqagg_dec
  import irqagg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 8,
  localparam int BSW       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  localparam int NUM_LINES = NUM_BLOCKS / 2
) (
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [1:0]            host_space,
  input  logic [ADDR_W-1:0]     host_addr,
  output logic [NUM_BLOCKS-1:0] mask_we,
  output logic [BSW-1:0]        sel_blk,
  output logic                  stat_rd,
  output logic                  vec_we,
  output logic                  ack_rd,
  output logic                  ack_hit
);

  space_e sp;
  logic   reg_hit;

  assign sp      = space_e'(host_space);
  assign sel_blk = host_addr[5 +: BSW];
  assign reg_hit = (sp == SP_REG) &&
                   ((host_addr >> (5 + BSW)) == '0) &&
                   (host_addr[4:0] == LOC_INTREG);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_we
    assign mask_we[b] = host_wr && reg_hit && (sel_blk == BSW'(b));
  end

  assign stat_rd = host_rd && reg_hit;
  assign vec_we  = host_wr && ((sp == SP_IDENT) || (sp == SP_MEM)) &&
                   (host_addr == ADDR_W'(1));
  assign ack_rd  = host_rd && (sp == SP_ACK);
  assign ack_hit = ack_rd && !host_addr[0] &&
                   ((host_addr >> 1) < ADDR_W'(NUM_LINES));

endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
  import irqagg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  parameter int ADDR_W     = 8,
  localparam int NUM_CH    = 2 * NUM_BLOCKS,
  localparam int NUM_LINES = NUM_BLOCKS / 2,
  localparam int BSW       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CH-1:0]    tx_set,
  input  logic [NUM_CH-1:0]    tx_clr,
  input  logic [NUM_CH-1:0]    rx_set,
  input  logic [NUM_CH-1:0]    rx_clr,
  input  logic [NUM_CH-1:0]    brk_set,
  input  logic [NUM_CH-1:0]    brk_clr,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [1:0]           host_space,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [STAT_W-1:0]    host_wdata,
  output logic [STAT_W-1:0]    host_rdata,
  output logic [NUM_LINES-1:0] irq_line
);

  logic [NUM_BLOCKS-1:0][STAT_W-1:0] set_vec, clr_vec;
  logic [NUM_BLOCKS-1:0][STAT_W-1:0] blk_status, blk_mask;
  logic [NUM_BLOCKS-1:0]             blk_pend;
  logic [NUM_BLOCKS-1:0]             dec_mask_we;
  logic [BSW-1:0]                    dec_sel_blk;
  logic                              dec_stat_rd, dec_vec_we, dec_ack_rd, dec_ack_hit;
  logic [NUM_LINES-1:0]              line_next;
  logic [STAT_W-1:0]                 vec_q;
  logic [STAT_W-1:0]                 rdata_d;

  irqagg_map #(.NUM_BLOCKS(NUM_BLOCKS)) u_map (
    .tx_set (tx_set),  .tx_clr (tx_clr),
    .rx_set (rx_set),  .rx_clr (rx_clr),
    .brk_set(brk_set), .brk_clr(brk_clr),
    .set_vec(set_vec), .clr_vec(clr_vec)
  );

  irqagg_dec #(.NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W)) u_dec (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_space(host_space),
    .host_addr (host_addr),
    .mask_we   (dec_mask_we),
    .sel_blk   (dec_sel_blk),
    .stat_rd   (dec_stat_rd),
    .vec_we    (dec_vec_we),
    .ack_rd    (dec_ack_rd),
    .ack_hit   (dec_ack_hit)
  );

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    irqagg_blk u_blk (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_vec   (set_vec[b]),
      .clr_vec   (clr_vec[b]),
      .mask_we   (dec_mask_we[b]),
      .mask_wdata(host_wdata),
      .status_q  (blk_status[b]),
      .mask_q    (blk_mask[b]),
      .pend      (blk_pend[b])
    );
  end

  // each line ORs the pending state of two neighbouring blocks
  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign line_next[l] = blk_pend[2*l] | blk_pend[2*l+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_line <= '0;
      vec_q    <= '0;
    end else begin
      irq_line <= line_next;
      if (dec_vec_we) vec_q <= host_wdata;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (dec_stat_rd)      rdata_d = blk_status[dec_sel_blk];
    else if (dec_ack_hit) rdata_d = vec_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rdata <= '0;
    else        host_rdata <= rdata_d;
  end

endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk
  import irqagg_pkg::*;
#(
  parameter int NUM_BLOCKS = 4,
  localparam int NUM_CH    = 2 * NUM_BLOCKS,
  localparam int NUM_LINES = NUM_BLOCKS / 2
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic [NUM_CH-1:0]                 tx_set,
  input logic [NUM_CH-1:0]                 tx_clr,
  input logic [NUM_CH-1:0]                 rx_set,
  input logic [NUM_CH-1:0]                 rx_clr,
  input logic [NUM_BLOCKS-1:0][STAT_W-1:0] blk_status,
  input logic [NUM_BLOCKS-1:0][STAT_W-1:0] blk_mask,
  input logic                              ack_rd,
  input logic                              ack_hit,
  input logic [STAT_W-1:0]                 host_rdata,
  input logic [NUM_LINES-1:0]              irq_line
);

  logic [NUM_LINES-1:0] chk_pend;
  always_comb begin
    for (int l = 0; l < NUM_LINES; l++)
      chk_pend[l] = ((blk_status[2*l] & blk_mask[2*l]) != '0) ||
                    ((blk_status[2*l+1] & blk_mask[2*l+1]) != '0);
  end

  // R1: lines and read data low in the cycle after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (irq_line == '0) && (host_rdata == '0));

  // R5: each line mirrors last cycle's masked status of its block pair
  a_r5_line_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> irq_line == $past(chk_pend));

  // R7: acknowledge at an unserviced address reads zero
  a_r7_ack_other_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(ack_rd && !ack_hit) |-> host_rdata == '0);

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_b
    // R2: the two unused status bits never rise
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_status[b][3] == 1'b0) && (blk_status[b][7] == 1'b0));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam int TXB = (c % 2) * 4 + FLAG_TX;
    localparam int RXB = (c % 2) * 4 + FLAG_RX;
    // R2: a lone set pulse raises the flag
    a_r2_tx_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(tx_set[c] && !tx_clr[c]) |-> blk_status[c/2][TXB]);
    a_r2_rx_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rx_set[c] && !rx_clr[c]) |-> blk_status[c/2][RXB]);
    // R3: a clear pulse wins, even against a set
    a_r3_tx_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(tx_clr[c]) |-> !blk_status[c/2][TXB]);
    a_r3_rx_clr_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) && $past(rx_clr[c]) |-> !blk_status[c/2][RXB]);
  end

endmodule

bind irqagg_top irqagg_chk #(.NUM_BLOCKS(NUM_BLOCKS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_set    (tx_set),
  .tx_clr    (tx_clr),
  .rx_set    (rx_set),
  .rx_clr    (rx_clr),
  .blk_status(blk_status),
  .blk_mask  (blk_mask),
  .ack_rd    (dec_ack_rd),
  .ack_hit   (dec_ack_hit),
  .host_rdata(host_rdata),
  .irq_line  (irq_line)
);

// File: tb/irqagg_top_test.sv
module irqagg_top_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] tx_set = '0, tx_clr = '0, rx_set = '0, rx_clr = '0, brk_set = '0, brk_clr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [1:0] host_space = '0;
  logic [7:0] host_addr = '0, host_wdata = '0;
  logic [7:0] host_rdata;
  logic [1:0] irq_line;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit cmp_on   = 1'b0;

  always #2 clk = ~clk;

  irqagg_top uut (
    .clk(clk), .rst_n(rst_n),
    .tx_set(tx_set), .tx_clr(tx_clr), .rx_set(rx_set), .rx_clr(rx_clr),
    .brk_set(brk_set), .brk_clr(brk_clr),
    .host_wr(host_wr), .host_rd(host_rd), .host_space(host_space),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq_line(irq_line)
  );

  // ---------------- behavioural reference ----------------
  int unsigned m_st[4];
  int unsigned m_mk[4];
  int unsigned m_vec;
  int unsigned m_rd;
  bit [1:0]    m_line;

  function automatic bit pulse_of(int f, int c, bit clr);
    case (f)
      0: return clr ? tx_clr[c]  : tx_set[c];
      1: return clr ? rx_clr[c]  : rx_set[c];
      default: return clr ? brk_clr[c] : brk_set[c];
    endcase
  endfunction

  always @(posedge clk) begin
    bit [1:0]    nl;
    int unsigned rdv;
    int unsigned bitm;
    if (!rst_n) begin
      foreach (m_st[i]) begin m_st[i] = 0; m_mk[i] = 0; end
      m_vec = 0; m_rd = 0; m_line = 0;
    end else begin
      for (int l = 0; l < 2; l++)
        nl[l] = ((m_st[2*l] & m_mk[2*l]) | (m_st[2*l+1] & m_mk[2*l+1])) != 0;
      rdv = 0;
      if (host_rd) begin
        if (host_space == 2'd0 && host_addr[7] == 1'b0 && host_addr[4:0] == 5'h0A)
          rdv = m_st[host_addr[6:5]];
        else if (host_space == 2'd2 && (host_addr == 8'd0 || host_addr == 8'd2))
          rdv = m_vec;
      end
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 3; f++) begin
          bitm = (32'd1 << f) << ((c & 1) ? 4 : 0);
          if (pulse_of(f, c, 1'b0)) m_st[c >> 1] = m_st[c >> 1] | bitm;
        end
      for (int c = 0; c < 8; c++)
        for (int f = 0; f < 3; f++) begin
          bitm = (32'd1 << f) << ((c & 1) ? 4 : 0);
          if (pulse_of(f, c, 1'b1)) m_st[c >> 1] = m_st[c >> 1] & ~bitm;
        end
      if (host_wr && host_space == 2'd0 && host_addr[7] == 1'b0 && host_addr[4:0] == 5'h0A)
        m_mk[host_addr[6:5]] = host_wdata;
      if (host_wr && (host_space == 2'd1 || host_space == 2'd3) && host_addr == 8'd1)
        m_vec = host_wdata;
      m_line = nl;
      m_rd   = rdv;
    end
    cmp_on = 1'b1;
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      check("R5 line vs model", irq_line, m_line);
      check("R7 rdata vs model", host_rdata, m_rd);
    end
  end

  // ---------------- drivers ----------------
  task automatic host_op(bit wr, bit rd, int sp, int addr, int data, output int rdat);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_space = 2'(sp);
    host_addr = 8'(addr); host_wdata = 8'(data);
    @(negedge clk);
    rdat = host_rdata;
    host_wr = 1'b0; host_rd = 1'b0; host_space = '0; host_addr = '0; host_wdata = '0;
  endtask

  task automatic write(int sp, int addr, int data);
    int d;
    host_op(1'b1, 1'b0, sp, addr, data, d);
  endtask

  task automatic read(int sp, int addr, output int d);
    host_op(1'b0, 1'b1, sp, addr, 0, d);
  endtask

  task automatic pulse(int f, int c, bit clr, bit both);
    @(negedge clk);
    case (f)
      0: begin tx_set[c] = !clr || both; tx_clr[c] = clr || both; end
      1: begin rx_set[c] = !clr || both; rx_clr[c] = clr || both; end
      default: begin brk_set[c] = !clr || both; brk_clr[c] = clr || both; end
    endcase
    @(negedge clk);
    tx_set = '0; tx_clr = '0; rx_set = '0; rx_clr = '0; brk_set = '0; brk_clr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic int stat_addr(int b);
    return (b << 5) | 'h0A;
  endfunction

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int d;
    int pick;
    int addr_opts[8];
    addr_opts = '{8'h0A, 8'h2A, 8'h4A, 8'h6A, 8'h01, 8'h00, 8'h02, 8'h0B};

    repeat (3) @(negedge clk);
    check("R1 line in reset", irq_line, 0);
    check("R1 rdata in reset", host_rdata, 0);
    rst_n = 1'b1;
    for (int b = 0; b < 4; b++) begin
      read(0, stat_addr(b), d);
      check("R1 status zero", d, 0);
    end
    read(2, 0, d);
    check("R1 vector zero", d, 0);

    // random phase, checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      tx_set  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      tx_clr  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rx_set  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rx_clr  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      brk_set = 8'($urandom) & 8'($urandom) & 8'($urandom);
      brk_clr = 8'($urandom) & 8'($urandom) & 8'($urandom);
      pick = int'($urandom_range(0, 9));
      host_space = 2'($urandom);
      host_addr  = (pick < 8) ? 8'(addr_opts[pick]) : 8'($urandom);
      host_wdata = 8'($urandom);
      host_wr    = ($urandom_range(0, 3) == 0);
      host_rd    = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk);
    tx_set = '0; tx_clr = '0; rx_set = '0; rx_clr = '0; brk_set = '0; brk_clr = '0;
    host_wr = 0; host_rd = 0;

    // directed phase
    do_reset();
    pulse(1, 3, 1'b0, 1'b0);
    read(0, stat_addr(1), d);
    check("R2 odd ch3 rx -> blk1 bit5", d, 'h20);
    pulse(0, 6, 1'b0, 1'b0);
    read(0, stat_addr(3), d);
    check("R2 even ch6 tx -> blk3 bit0", d, 'h01);
    pulse(2, 0, 1'b0, 1'b0);
    pulse(2, 1, 1'b0, 1'b0);
    read(0, stat_addr(0), d);
    check("R2 break ch0/ch1 -> bits 2,6", d, 'h44);

    pulse(1, 2, 1'b0, 1'b1);
    read(0, stat_addr(1), d);
    check("R3 set+clr same cycle", d, 'h20);
    pulse(1, 3, 1'b1, 1'b0);
    read(0, stat_addr(1), d);
    check("R3 clear alone", d, 'h00);

    pulse(1, 3, 1'b0, 1'b0);
    check("R5 line low before mask", irq_line, 0);
    write(0, 'h0B | (1 << 5), 'hFF);
    check("R8 wrong offset no mask", irq_line, 0);
    @(negedge clk);
    check("R8 wrong offset no mask later", irq_line, 0);
    write(0, stat_addr(1), 'h20);
    check("R5 line latency one cycle", irq_line, 0);
    @(negedge clk);
    check("R4 R5 mask raises line0", irq_line, 1);
    write(0, stat_addr(3), 'h01);
    @(negedge clk);
    check("R5 line1 from block3", irq_line, 3);
    write(0, stat_addr(1), 'h00);
    @(negedge clk);
    check("R5 line0 drops with mask", irq_line, 2);

    write(1, 1, 'h5A);
    read(2, 0, d);
    check("R6 R7 vector via ident", d, 'h5A);
    write(3, 1, 'hC3);
    read(2, 2, d);
    check("R6 R7 vector via mem, line1 ack", d, 'hC3);
    write(1, 3, 'h11);
    read(2, 0, d);
    check("R6 other ident addr ignored", d, 'hC3);
    read(2, 4, d);
    check("R7 ack other addr zero", d, 0);
    check("R7 ack leaves lines", irq_line, 2);
    read(0, 'h8A, d);
    check("R8 addr bit7 read zero", d, 0);
    read(0, 'h0C, d);
    check("R8 unmapped offset read zero", d, 0);
    @(negedge clk);
    check("R8 rdata zero without read", host_rdata, 0);

    repeat (2) @(negedge clk);
    report();
  end

endmodule